// File: doc/BRIEF.md
# Dimming-Aware Peak-Current Gate Controller

This block is the digital core of a constant-frequency, peak-current-mode boost controller with pulse-width dimming. It builds the switching period from a counter of system clocks and turns the main switch on at the start of each period. The gate turns off when the external peak-current comparator trips or when the maximum on-time is reached. The comparator is not looked at for a short leading-edge blanking window after each turn-on.

The block also drives two more outputs. One is the load-disconnect switch command. The other is a strobe that connects the error amplifier to the compensation node. A low dimming input opens the load switch and releases the strobe, so the compensation node keeps its charge. The switching period is held off while dimming is low, and it restarts in phase with each rising edge.

Short dimming pulses need one special case. A gate pulse that is already running when dimming falls is not cut by the duty limit. It is stretched until the current comparator trips, so the inductor still reaches its target current. The over-voltage comparator and the enable from the fault sequencer both force the outputs off.

Top module: `dimpwm_gate_ctrl`

## Requirements
- R1: While the synchronized dimming level is low, no gate pulse starts. The first gate pulse is seen 3 clocks after the dimming input rises: 2 synchronizer flops plus the gate register. Later pulses start every PERIOD_CYC clocks.
- R2: With dimming high and the comparator never tripping, each gate pulse lasts exactly MAXON_CYC clocks. By default MAXON_CYC is 900 per mille of the period, which sits inside the 87 to 93 % band.
- R3: A comparator trip seen on the k-th clock of a pulse, where k counts from 0 and k is at least BLANK_CYC, ends the pulse on the next clock, giving a width of k+1.
- R4: A comparator trip during the first BLANK_CYC clocks of a pulse is ignored. BLANK_CYC defaults to the clocks covering 100 ns.
- R5: The load-disconnect output and the amplifier strobe go low 3 clocks after the dimming input falls.
- R6: A pulse in progress when dimming falls runs past MAXON_CYC and ends only on an unblanked comparator trip. No new pulse follows while dimming stays low.
- R7: With dimming high, enable high and no over-voltage, the load-disconnect output and the amplifier strobe are high.
- R8: An active over-voltage input drives the gate and the load-disconnect output low on the next clock and keeps them low. Once it clears, the load switch closes on the next clock and pulses resume at the next period start.
- R9: A low enable drives all three outputs low on the next clock and clears the period counter. When enable returns with dimming high, a fresh period starts, and the gate is high one clock later.
- R10: During and right after reset, all three outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Run enable from the fault sequencer |
| dim_i | input | 1 | Asynchronous pulse-width dimming input |
| ipk_trip_i | input | 1 | Peak-current comparator trip |
| ovp_i | input | 1 | Over-voltage comparator output |
| gate_o | output | 1 | Main switch gate command |
| ldsw_o | output | 1 | Load-disconnect switch command |
| ea_conn_o | output | 1 | Error-amplifier connect strobe |

## Verification
The bench builds the block with PERIOD_CYC = 40, BLANK_CYC = 4, and the default 900 per-mille duty setting, which gives a 36-clock on-time. These small values let one run see several full periods, and they put the blanking edge, the duty limit and the period boundary only a few clocks apart. As a result, each of them can be hit on an exact clock. A stretched pulse can also be driven well past the duty limit, and the enable and over-voltage recoveries can be timed against the next period start, all within a few hundred clocks.

// File: rtl/dimpwm_pkg.sv
package dimpwm_pkg;

  // Gate pulse state: idle, duty-limited on, or stretched after dimming falls
  typedef enum logic [1:0] {
    GS_IDLE    = 2'd0,
    GS_ON      = 2'd1,
    GS_STRETCH = 2'd2
  } gate_state_t;

  // Clocks needed to cover a time in ns, rounded up
  function automatic int unsigned ns_to_cyc(input int unsigned ns,
                                            input int unsigned clk_ps);
    return (ns * 1000 + clk_ps - 1) / clk_ps;
  endfunction

  // On-time in clocks for a duty given in per mille of the period
  function automatic int unsigned duty_cyc(input int unsigned per,
                                           input int unsigned permille);
    return (per * permille) / 1000;
  endfunction

endpackage

// File: rtl/dimpwm_sync_edge.sv
module dimpwm_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o,
  output logic fall_o
);
  logic [STAGES-1:0] sh_q;
  logic              prev_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= {sh_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= sh_q[STAGES-1];
  end

  assign lvl_o  = sh_q[STAGES-1];
  assign rise_o = sh_q[STAGES-1] & ~prev_q;
  assign fall_o = ~sh_q[STAGES-1] & prev_q;
endmodule

// File: rtl/dimpwm_period_timer.sv
module dimpwm_period_timer #(
  parameter int unsigned PERIOD_CYC = 1000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  output logic start_o
);
  localparam int unsigned PW = (PERIOD_CYC > 1) ? $clog2(PERIOD_CYC) : 1;
  localparam logic [PW-1:0] LAST = PW'(PERIOD_CYC - 1);

  logic [PW-1:0] cnt_q;

  // Counter sits at zero while stopped, so a restart begins a full period
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run_i)        cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                    cnt_q <= cnt_q + 1'b1;
  end

  assign start_o = run_i & (cnt_q == '0);

  // R1: once running, the next period start is exactly PERIOD_CYC clocks on
  assert_period_wrap_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (run_i && cnt_q == LAST) |=> (!run_i || start_o));
endmodule

// File: rtl/dimpwm_gate_fsm.sv
module dimpwm_gate_fsm
  import dimpwm_pkg::*;
#(
  parameter int unsigned MAXON_CYC = 900,
  parameter int unsigned BLANK_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic dim_i,
  input  logic start_i,
  input  logic trip_i,
  input  logic ovp_i,
  output logic gate_o
);
  localparam int unsigned OW = $clog2(MAXON_CYC + 1) + 1;
  localparam logic [OW-1:0] BLANK_V = OW'(BLANK_CYC);
  localparam logic [OW-1:0] LIMIT_V = OW'(MAXON_CYC - 1);

  gate_state_t   st_q, st_d;
  logic [OW-1:0] on_cnt_q;
  logic          unblanked;
  logic          trip_hit;
  logic          duty_hit;
  logic          kill;

  assign unblanked = (on_cnt_q >= BLANK_V);
  assign trip_hit  = trip_i & unblanked;
  assign duty_hit  = (on_cnt_q >= LIMIT_V);
  assign kill      = ~en_i | ovp_i;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      GS_IDLE: begin
        if (start_i && !kill) st_d = GS_ON;
      end
      GS_ON: begin
        if (kill || trip_hit)       st_d = GS_IDLE;
        else if (!dim_i)            st_d = GS_STRETCH;
        else if (duty_hit)          st_d = GS_IDLE;
      end
      GS_STRETCH: begin
        if (kill || trip_hit)       st_d = GS_IDLE;
        else if (dim_i)             st_d = GS_ON;
      end
      default: st_d = GS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q     <= GS_IDLE;
      on_cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_d == GS_IDLE || st_q == GS_IDLE) on_cnt_q <= '0;
      else if (on_cnt_q != '1)                on_cnt_q <= on_cnt_q + 1'b1;
    end
  end

  assign gate_o = (st_q != GS_IDLE);

  // R4: a trip inside the blanking window never ends a pulse
  assert_blank_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_o && !unblanked && en_i && !ovp_i && !(dim_i && duty_hit)) |=> gate_o);

  // R6: with dimming low, an idle gate stays idle
  assert_no_start_dim_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_o && !dim_i) |=> !gate_o);

  // R6: a stretched pulse ends only on trip or fault
  assert_stretch_keep_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == GS_STRETCH && !trip_i && en_i && !ovp_i) |=> gate_o);
endmodule

// File: rtl/dimpwm_gate_ctrl.sv
module dimpwm_gate_ctrl
  import dimpwm_pkg::*;
#(
  parameter int unsigned CLK_PS        = 10000,
  parameter int unsigned PERIOD_CYC    = 1000,
  parameter int unsigned DUTY_PERMILLE = 900,
  parameter int unsigned MAXON_CYC     = duty_cyc(PERIOD_CYC, DUTY_PERMILLE),
  parameter int unsigned BLANK_CYC     = ns_to_cyc(100, CLK_PS),
  parameter int unsigned SYNC_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic dim_i,
  input  logic ipk_trip_i,
  input  logic ovp_i,
  output logic gate_o,
  output logic ldsw_o,
  output logic ea_conn_o
);
  logic dim_lvl, dim_rise, dim_fall;
  logic per_start;
  logic ldsw_q, ea_q;

  dimpwm_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .d_i    (dim_i),
    .lvl_o  (dim_lvl),
    .rise_o (dim_rise),
    .fall_o (dim_fall)
  );

  dimpwm_period_timer #(.PERIOD_CYC(PERIOD_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run_i   (en_i & dim_lvl),
    .start_o (per_start)
  );

  dimpwm_gate_fsm #(.MAXON_CYC(MAXON_CYC), .BLANK_CYC(BLANK_CYC)) u_fsm (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (en_i),
    .dim_i   (dim_lvl),
    .start_i (per_start),
    .trip_i  (ipk_trip_i),
    .ovp_i   (ovp_i),
    .gate_o  (gate_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ldsw_q <= 1'b0;
      ea_q   <= 1'b0;
    end else begin
      ldsw_q <= en_i & dim_lvl & ~ovp_i;
      ea_q   <= en_i & dim_lvl;
    end
  end

  assign ldsw_o    = ldsw_q;
  assign ea_conn_o = ea_q;

  // R1: a dimming rising edge with enable high begins a period at once
  assert_rise_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (dim_rise && en_i) |-> per_start);

  // R5: after a dimming falling edge the strobe and load switch are released
  assert_fall_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dim_fall |=> (!ea_conn_o && !ldsw_o));

  // R8: over-voltage opens both switches on the next clock
  assert_ovp_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ovp_i |=> (!gate_o && !ldsw_o));

  // R9: a low enable clears every output on the next clock
  assert_en_off_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> (!gate_o && !ldsw_o && !ea_conn_o));
endmodule

// File: tb/dimpwm_gate_ctrl_bench.sv
module dimpwm_gate_ctrl_bench;
  localparam int unsigned PER   = 40;
  localparam int unsigned MAXON = 36;
  localparam int unsigned BLANK = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b0, dim = 1'b0, trip = 1'b0, ovp = 1'b0;
  logic gate, ldsw, ea;
  int   n_chk = 0, n_fail = 0;
  bit   done = 1'b0;

  always #5 clk = ~clk;

  dimpwm_gate_ctrl #(.PERIOD_CYC(PER), .BLANK_CYC(BLANK)) u_dimpwm_gate_ctrl (
    .clk(clk), .rst_n(rst_n), .en_i(en), .dim_i(dim), .ipk_trip_i(trip),
    .ovp_i(ovp), .gate_o(gate), .ldsw_o(ldsw), .ea_conn_o(ea)
  );

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wait_gate(input logic val, input int limit, output int waited);
    waited = 0;
    while (gate !== val && waited < limit) begin
      step();
      waited++;
    end
  endtask

  // width of the current pulse, gate already high at this sample
  task automatic pulse_width(input int limit, output int w);
    w = 0;
    while (gate === 1'b1 && w < limit) begin
      step();
      w++;
    end
  endtask

  task automatic t_reset_r10();
    chk("R10", gate, 0, "gate in reset");
    chk("R10", ldsw, 0, "ldsw in reset");
    rst_n = 1'b1;
    en = 1'b1;
    step();
    chk("R10", gate, 0, "gate after reset");
    chk("R10", ea, 0, "strobe after reset");
  endtask

  task automatic t_holdoff_r1();
    int highs = 0;
    for (int i = 0; i < 60; i++) begin
      step();
      if (gate) highs++;
    end
    chk("R1", highs, 0, "gate highs while dimming low");
  endtask

  task automatic t_start_r1_r2_r7();
    int w, lo;
    dim = 1'b1;
    step();
    chk("R1", gate, 0, "gate after 1 clock");
    step();
    chk("R1", gate, 0, "gate after 2 clocks");
    step();
    chk("R1", gate, 1, "gate after 3 clocks");
    chk("R7", ldsw, 1, "ldsw with dimming high");
    chk("R7", ea, 1, "strobe with dimming high");
    pulse_width(200, w);
    chk("R2", w, MAXON, "duty-limited width");
    wait_gate(1'b1, 200, lo);
    chk("R1", w + lo, PER, "period between rises");
  endtask

  task automatic t_trip_r3_r4();
    int w, lo;
    wait_gate(1'b0, 200, lo);
    wait_gate(1'b1, 200, lo);
    trip = 1'b1;
    pulse_width(200, w);
    chk("R4", w, BLANK + 1, "width with trip held from turn-on");
    trip = 1'b0;
    wait_gate(1'b1, 200, lo);
    for (int k = 0; k < 10; k++) step();
    chk("R3", gate, 1, "gate before late trip");
    trip = 1'b1;
    step();
    chk("R3", gate, 0, "gate one clock after unblanked trip");
    trip = 1'b0;
  endtask

  task automatic t_stretch_r5_r6();
    int lo, highs = 0;
    wait_gate(1'b0, 200, lo);
    wait_gate(1'b1, 200, lo);
    dim = 1'b0;
    step();
    chk("R5", ldsw, 1, "ldsw 1 clock after fall");
    step();
    chk("R5", ea, 1, "strobe 2 clocks after fall");
    step();
    chk("R5", ldsw, 0, "ldsw 3 clocks after fall");
    chk("R5", ea, 0, "strobe 3 clocks after fall");
    for (int k = 3; k < 60; k++) step();
    chk("R6", gate, 1, "stretched gate past duty limit");
    trip = 1'b1;
    step();
    chk("R6", gate, 0, "stretched gate ends on trip");
    trip = 1'b0;
    for (int k = 0; k < 100; k++) begin
      step();
      if (gate) highs++;
    end
    chk("R6", highs, 0, "no pulse after stretch");
  endtask

  task automatic t_ovp_r8();
    int lo, highs = 0;
    dim = 1'b1;
    wait_gate(1'b1, 200, lo);
    step();
    step();
    ovp = 1'b1;
    step();
    chk("R8", gate, 0, "gate after over-voltage");
    chk("R8", ldsw, 0, "ldsw after over-voltage");
    for (int k = 0; k < 50; k++) begin
      step();
      if (gate) highs++;
    end
    chk("R8", highs, 0, "gate highs during over-voltage");
    ovp = 1'b0;
    step();
    chk("R8", ldsw, 1, "ldsw after clear");
    wait_gate(1'b1, PER + 2, lo);
    chk("R8", gate, 1, "pulse resumes within a period");
  endtask

  task automatic t_en_r9();
    int lo, w, highs = 0;
    step();
    step();
    step();
    en = 1'b0;
    step();
    chk("R9", gate, 0, "gate after disable");
    chk("R9", ldsw, 0, "ldsw after disable");
    chk("R9", ea, 0, "strobe after disable");
    for (int k = 0; k < 20; k++) begin
      step();
      if (gate) highs++;
    end
    chk("R9", highs, 0, "gate highs while disabled");
    en = 1'b1;
    step();
    chk("R9", gate, 1, "fresh period on re-enable");
    pulse_width(200, w);
    chk("R2", w, MAXON, "width after re-enable");
    wait_gate(1'b1, 200, lo);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r10();
    t_holdoff_r1();
    t_start_r1_r2_r7();
    t_trip_r3_r4();
    t_stretch_r5_r6();
    t_ovp_r8();
    t_en_r9();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule